// File: doc/BRIEF.md
# Lock Elision Conflict Tracker

This block lets a core run a lock-protected critical section without taking the lock. It records which cache blocks the section touches and holds back its stores. While the section runs speculatively, every load and store sets an access bit on its cache block. Each store goes into a small write buffer that merges by block, and an exclusive-ownership request is raised for the stored block. Nothing the section writes is visible outside until commit.

Coherence snoops are compared against the access bits. If an invalidation or an exclusive-ownership request from another agent hits a touched block, the section has lost atomicity. A store that needs a new buffer entry when none is free also ends the section. Either event aborts: the buffer and all access bits clear in one cycle, and a pulse asks the core to restore the register checkpoint it saved on entry. If the section reaches its end with no abort, the buffer drains one entry per cycle. Snoops are held off for the whole drain, so other agents see all of the section's writes or none of them.

Blocks are named by an index into a direct-mapped tag space of `NBLK` entries. The write buffer holds `WB_DEPTH` distinct blocks.

Top module: `lel_tracker`

## Requirements
- R1: With the mode idle (mode_o=0), `sec_begin` raises `ckpt_save` in the same cycle and mode_o becomes speculative (1) on the next cycle. `sec_begin` in any other mode raises no `ckpt_save` and has no effect.
- R2: In speculative mode, an accepted store raises `excl_req_valid` with `excl_req_addr` equal to `acc_addr` in the same cycle. The store data does not appear on `wr_valid` before commit.
- R3: In speculative mode, every accepted load or store sets the access bit of block `acc_addr`.
- R4: In speculative mode, a snoop with kind 1 (invalidate) to a block whose access bit is set moves the mode to abort (3) on the next cycle. Kind 0 (shared read) and kind 3 (no-op) never cause an abort.
- R5: In speculative mode, a snoop with kind 2 (exclusive request) to a block whose access bit is set moves the mode to abort on the next cycle.
- R6: A speculative store to a block not in the buffer while the buffer already holds `WB_DEPTH` blocks causes an abort on the next cycle. That store is not accepted and raises no `excl_req_valid`.
- R7: A later speculative store to a block already in the buffer overwrites that entry's data and does not take a new entry.
- R8: `sec_end` in speculative mode with no abort condition moves the mode to commit (2). The buffer then drains one entry per cycle on `wr_valid`/`wr_addr`/`wr_data`, in order of first allocation. The next cycle pulses `commit_done`, after which the mode is idle.
- R9: `snp_hold` is high for every commit cycle, and snoops presented during commit cause no abort and no change to the drain.
- R10: The abort mode lasts exactly one cycle with `ckpt_restore` high, then the mode is idle. The buffer and all access bits are empty afterwards.
- R11: Outside speculative mode, loads and stores set no access bits and snoops never cause an abort.
- R12: While reset is asserted and after its release, the mode is idle and all outputs are low.
- R13: An abort condition in the same cycle as `sec_end` wins, giving abort rather than commit. An accepted access in the same cycle as `sec_end` belongs to the section and is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_begin | input | 1 | Start of an elided critical section |
| sec_end | input | 1 | End of the critical section |
| acc_valid | input | 1 | Core memory access this cycle |
| acc_is_store | input | 1 | Access is a store (1) or load (0) |
| acc_addr | input | AW | Block index of the access |
| acc_data | input | DW | Store data |
| snp_valid | input | 1 | Incoming coherence snoop |
| snp_kind | input | 2 | 0 shared read, 1 invalidate, 2 exclusive request, 3 no-op |
| snp_addr | input | AW | Block index of the snoop |
| snp_hold | output | 1 | Snoop responses held off (commit in progress) |
| excl_req_valid | output | 1 | Request exclusive ownership for a buffered store |
| excl_req_addr | output | AW | Block for the exclusive request |
| ckpt_save | output | 1 | Save register checkpoint |
| ckpt_restore | output | 1 | Restore register checkpoint (abort) |
| wr_valid | output | 1 | Committed write beat |
| wr_addr | output | AW | Block of the committed write |
| wr_data | output | DW | Data of the committed write |
| commit_done | output | 1 | Commit finished |
| mode_o | output | 2 | 0 idle, 1 speculative, 2 commit, 3 abort |

## Verification
Some properties hold on every cycle, and the bound checker tests them there. The buffer count never exceeds its depth. Access bits and buffer are empty whenever the mode is idle, and both are empty after an abort. Abort lasts one cycle. Checkpoint saves and exclusive requests come only from the correct modes. Commit writes appear only while snoops are held off. Other behaviour depends on sequences and only the bench scenarios show it. These include merging by block, drain order and data, the priority of an abort over `sec_end`, which snoop kinds conflict, and the fact that snoops during commit or outside speculation are ignored.

// File: rtl/lel_pkg.sv
`timescale 1ns/1ps
package lel_pkg;
  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_SPEC   = 2'd1,
    M_COMMIT = 2'd2,
    M_ABORT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SNP_RD   = 2'd0,
    SNP_INV  = 2'd1,
    SNP_EXCL = 2'd2,
    SNP_NONE = 2'd3
  } snp_kind_e;
endpackage

// File: rtl/lel_fsm.sv
`timescale 1ns/1ps
module lel_fsm
  import lel_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_begin,
  input  logic          sec_end,
  input  logic          kill,
  input  logic [CW-1:0] cnt,
  output mode_e         state,
  output logic [CW-1:0] idx,
  output logic          done
);
  mode_e         state_d;
  logic [CW-1:0] idx_d;

  always_comb begin
    state_d = state;
    idx_d   = idx;
    case (state)
      M_IDLE: begin
        idx_d = '0;
        if (sec_begin) state_d = M_SPEC;
      end
      M_SPEC: begin
        idx_d = '0;
        if (kill)         state_d = M_ABORT;
        else if (sec_end) state_d = M_COMMIT;
      end
      M_COMMIT: begin
        if (idx != cnt) begin
          idx_d = idx + 1'b1;
        end else begin
          idx_d   = '0;
          state_d = M_IDLE;
        end
      end
      M_ABORT: state_d = M_IDLE;
      default: state_d = M_IDLE;
    endcase
  end

  assign done = (state == M_COMMIT) && (idx == cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= M_IDLE;
      idx   <= '0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
    end
  end
endmodule

// File: rtl/lel_access_bits.sv
`timescale 1ns/1ps
module lel_access_bits #(
  parameter int NBLK = 16,
  localparam int AW = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [AW-1:0] q_addr,
  output logic          q_bit,
  output logic          any_set
);
  logic [NBLK-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (clr) begin
      bits_q <= '0;
    end else if (set_en) begin
      bits_q[set_addr] <= 1'b1;
    end
  end

  assign q_bit   = bits_q[q_addr];
  assign any_set = |bits_q;
endmodule

// File: rtl/lel_write_buf.sv
`timescale 1ns/1ps
module lel_write_buf #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          st_en,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          hit,
  output logic          full,
  input  logic [CW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] cnt
);
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0] match;
  logic [IW-1:0] hit_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (CW'(i) < cnt) && (ent_addr[i] == st_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit  = |match;
  assign full = (cnt == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (st_en && !hit && !full) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_en && !clr) begin
      if (hit) begin
        ent_data[hit_idx] <= st_data;
      end else if (!full) begin
        ent_addr[cnt[IW-1:0]] <= st_addr;
        ent_data[cnt[IW-1:0]] <= st_data;
      end
    end
  end

  assign rd_addr = ent_addr[rd_idx[IW-1:0]];
  assign rd_data = ent_data[rd_idx[IW-1:0]];
endmodule

// File: rtl/lel_tracker.sv
`timescale 1ns/1ps
module lel_tracker
  import lel_pkg::*;
#(
  parameter int NBLK     = 16,
  parameter int DW       = 32,
  parameter int WB_DEPTH = 4,
  localparam int AW = $clog2(NBLK),
  localparam int CW = $clog2(WB_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_begin,
  input  logic          sec_end,
  input  logic          acc_valid,
  input  logic          acc_is_store,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_kind,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hold,
  output logic          excl_req_valid,
  output logic [AW-1:0] excl_req_addr,
  output logic          ckpt_save,
  output logic          ckpt_restore,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          commit_done,
  output logic [1:0]    mode_o
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  mode_e         state;
  logic [CW-1:0] drain_idx;
  logic [CW-1:0] wb_cnt;
  logic          drain_done;
  logic          in_spec, snp_bit, snp_conf, overflow, kill, acc_ok;
  logic          wb_hit, wb_full, clr_all, abits_any;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign in_spec  = (state == M_SPEC);
  assign snp_conf = in_spec && snp_valid && snp_bit &&
                    ((snp_kind == SNP_INV) || (snp_kind == SNP_EXCL));
  assign overflow = in_spec && acc_valid && acc_is_store && !wb_hit && wb_full;
  assign kill     = snp_conf || overflow;
  assign acc_ok   = in_spec && acc_valid && !kill;
  assign clr_all  = (state == M_ABORT) || drain_done;

  lel_fsm #(.CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sec_begin (sec_begin),
    .sec_end   (sec_end),
    .kill      (kill),
    .cnt       (wb_cnt),
    .state     (state),
    .idx       (drain_idx),
    .done      (drain_done)
  );

  lel_access_bits #(.NBLK(NBLK)) u_abits (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (clr_all),
    .set_en   (acc_ok),
    .set_addr (acc_addr),
    .q_addr   (snp_addr),
    .q_bit    (snp_bit),
    .any_set  (abits_any)
  );

  lel_write_buf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (clr_all),
    .st_en   (acc_ok && acc_is_store),
    .st_addr (acc_addr),
    .st_data (acc_data),
    .hit     (wb_hit),
    .full    (wb_full),
    .rd_idx  (drain_idx),
    .rd_addr (wr_addr),
    .rd_data (wr_data),
    .cnt     (wb_cnt)
  );

  assign snp_hold       = (state == M_COMMIT);
  assign excl_req_valid = acc_ok && acc_is_store;
  assign excl_req_addr  = acc_addr;
  assign ckpt_save      = (state == M_IDLE) && sec_begin;
  assign ckpt_restore   = (state == M_ABORT);
  assign wr_valid       = (state == M_COMMIT) && (drain_idx != wb_cnt);
  assign commit_done    = drain_done;
  assign mode_o         = state;
endmodule

// File: rtl/lel_tracker_chk.sv
`timescale 1ns/1ps
module lel_tracker_chk
  import lel_pkg::*;
#(
  parameter int WB_DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          ckpt_save,
  input logic          ckpt_restore,
  input logic          snp_hold,
  input logic          wr_valid,
  input logic          commit_done,
  input logic          excl_req_valid,
  input logic          abits_any,
  input logic [CW-1:0] wb_cnt
);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= CW'(WB_DEPTH));

  a_r1_save_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save |-> (mode == M_IDLE));

  a_r2_excl_in_spec: assert property (@(posedge clk) disable iff (!rst_n)
    excl_req_valid |-> (mode == M_SPEC));

  a_r10_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> (mode == M_IDLE));

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> (!abits_any && wb_cnt == '0));

  a_r11_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE) |-> (!abits_any && wb_cnt == '0));

  a_r9_write_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> snp_hold);

  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (mode == M_IDLE && !wr_valid));
endmodule

bind lel_tracker lel_tracker_chk #(.WB_DEPTH(WB_DEPTH), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode           (mode_o),
  .ckpt_save      (ckpt_save),
  .ckpt_restore   (ckpt_restore),
  .snp_hold       (snp_hold),
  .wr_valid       (wr_valid),
  .commit_done    (commit_done),
  .excl_req_valid (excl_req_valid),
  .abits_any      (abits_any),
  .wb_cnt         (wb_cnt)
);

// File: tb/lel_tracker_bench.sv
`timescale 1ns/1ps
module lel_tracker_bench;
  localparam int NBLK = 16;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sec_begin, sec_end, acc_valid, acc_is_store, snp_valid;
  logic [AW-1:0] acc_addr, snp_addr;
  logic [DW-1:0] acc_data;
  logic [1:0] snp_kind;
  logic snp_hold, excl_req_valid, ckpt_save, ckpt_restore, wr_valid, commit_done;
  logic [AW-1:0] excl_req_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0] mode_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string scen = "R12";

  // reference model state
  int m_state = 0;
  bit [NBLK-1:0] m_bits = '0;
  int unsigned qa[$];
  int unsigned qd[$];
  int m_idx = 0;
  int wr_seen = 0, done_seen = 0, abort_seen = 0;

  always #2.5 clk = ~clk;

  lel_tracker #(.NBLK(NBLK), .DW(DW), .WB_DEPTH(DEPTH)) u_lel_tracker (
    .clk(clk), .rst_n(rst_n), .sec_begin(sec_begin), .sec_end(sec_end),
    .acc_valid(acc_valid), .acc_is_store(acc_is_store), .acc_addr(acc_addr),
    .acc_data(acc_data), .snp_valid(snp_valid), .snp_kind(snp_kind),
    .snp_addr(snp_addr), .snp_hold(snp_hold), .excl_req_valid(excl_req_valid),
    .excl_req_addr(excl_req_addr), .ckpt_save(ckpt_save),
    .ckpt_restore(ckpt_restore), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_done(commit_done), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s/%s] %s actual=%0d expected=%0d", req, scen, what, act, exp);
    end
  endtask

  task automatic step(input bit sb, input bit se, input bit av, input bit ast,
                      input int aa, input int ad, input bit sv, input int sk,
                      input int sa);
    bit spec, conf, hit, ovf, kill, e_excl, e_wrv, e_done;
    int hi;
    @(negedge clk);
    sec_begin = sb; sec_end = se; acc_valid = av; acc_is_store = ast;
    acc_addr = AW'(aa); acc_data = DW'(ad); snp_valid = sv;
    snp_kind = 2'(sk); snp_addr = AW'(sa);
    #1;
    spec = (m_state == 1);
    conf = spec && sv && (sk == 1 || sk == 2) && m_bits[sa];
    hi = -1;
    foreach (qa[i]) if (qa[i] == aa) hi = i;
    hit = (hi >= 0);
    ovf = spec && av && ast && !hit && (qa.size() == DEPTH);
    kill = conf || ovf;
    e_excl = spec && av && ast && !kill;
    e_wrv = (m_state == 2) && (m_idx < qa.size());
    e_done = (m_state == 2) && (m_idx == qa.size());
    chk(mode_o == 2'(m_state), "R1", "mode", mode_o, m_state);
    chk(ckpt_save == (m_state == 0 && sb), "R1", "ckpt_save", ckpt_save, m_state == 0 && sb);
    chk(snp_hold == (m_state == 2), "R9", "snp_hold", snp_hold, m_state == 2);
    chk(ckpt_restore == (m_state == 3), "R10", "ckpt_restore", ckpt_restore, m_state == 3);
    chk(excl_req_valid == e_excl, "R2", "excl_req_valid", excl_req_valid, e_excl);
    if (e_excl) chk(excl_req_addr == AW'(aa), "R2", "excl_req_addr", excl_req_addr, aa);
    chk(wr_valid == e_wrv, "R8", "wr_valid", wr_valid, e_wrv);
    if (e_wrv) begin
      chk(wr_addr == AW'(qa[m_idx]), "R8", "wr_addr", wr_addr, qa[m_idx]);
      chk(wr_data == DW'(qd[m_idx]), "R8", "wr_data", wr_data, qd[m_idx]);
    end
    chk(commit_done == e_done, "R8", "commit_done", commit_done, e_done);
    if (wr_valid) wr_seen++;
    if (commit_done) done_seen++;
    if (ckpt_restore) abort_seen++;
    @(posedge clk);
    case (m_state)
      0: if (sb) m_state = 1;
      1: begin
        if (kill) m_state = 3;
        else begin
          if (av) begin
            m_bits[aa] = 1'b1;
            if (ast) begin
              if (hit) qd[hi] = ad;
              else begin qa.push_back(aa); qd.push_back(ad); end
            end
          end
          if (se) begin m_state = 2; m_idx = 0; end
        end
      end
      2: begin
        if (m_idx < qa.size()) m_idx++;
        else begin m_bits = '0; qa.delete(); qd.delete(); m_state = 0; end
      end
      default: begin m_bits = '0; qa.delete(); qd.delete(); m_state = 0; end
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ld(input int a);
    step(0, 0, 1, 0, a, 0, 0, 0, 0);
  endtask

  task automatic st(input int a, input int d);
    step(0, 0, 1, 1, a, d, 0, 0, 0);
  endtask

  task automatic snp(input int k, input int a);
    step(0, 0, 0, 0, 0, 0, 1, k, a);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL [R8] watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w0, d0, a0;
    rst_n = 1'b0;
    sec_begin = 0; sec_end = 0; acc_valid = 0; acc_is_store = 0; acc_addr = '0;
    acc_data = '0; snp_valid = 0; snp_kind = '0; snp_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk(mode_o == 2'd0 && !wr_valid && !commit_done && !ckpt_save && !ckpt_restore
        && !snp_hold && !excl_req_valid, "R12", "reset outputs", mode_o, 0);
    rst_n = 1'b1;
    idle(4);

    // R11: accesses and snoops outside elision have no effect
    scen = "R11";
    ld(3); st(4, 44); snp(1, 3); snp(2, 4);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    snp(1, 3); snp(2, 4);
    chk(mode_o == 2'd1, "R11", "no abort from idle-time accesses", mode_o, 1);
    w0 = wr_seen; d0 = done_seen;
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    chk(wr_seen == w0 && done_seen == d0 + 1, "R11", "empty commit beats", wr_seen - w0, 0);

    // R2 R3 R7 R13 R4: merge, harmless snoops, access with sec_end
    scen = "R7";
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0); // R1: second begin ignored
    st(3, 100); ld(5); st(7, 200); st(3, 300);
    snp(0, 3); snp(3, 5); snp(1, 12); // R4: read/no-op/untouched never conflict
    chk(mode_o == 2'd1, "R4", "still speculative", mode_o, 1);
    w0 = wr_seen;
    scen = "R13";
    step(0, 1, 1, 1, 9, 400, 0, 0, 0);
    idle(6);
    chk(wr_seen - w0 == 3, "R7", "merged write count", wr_seen - w0, 3);

    // R4 R10: invalidate on a loaded block aborts; state is cleared after
    scen = "R4";
    a0 = abort_seen;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    ld(6); st(11, 5); snp(1, 6);
    idle(2);
    chk(abort_seen == a0 + 1, "R4", "abort count", abort_seen - a0, 1);
    scen = "R10";
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    snp(1, 6); snp(2, 11); // R3 bits cleared by abort
    chk(mode_o == 2'd1, "R10", "bits cleared", mode_o, 1);
    w0 = wr_seen;
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    chk(wr_seen == w0, "R10", "buffer cleared", wr_seen - w0, 0);

    // R5 R13: exclusive snoop on stored block with sec_end in same cycle
    scen = "R5";
    a0 = abort_seen; d0 = done_seen;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    st(2, 77);
    step(0, 1, 0, 0, 0, 0, 1, 2, 2);
    idle(2);
    chk(abort_seen == a0 + 1 && done_seen == d0, "R13", "abort beats commit",
        abort_seen - a0, 1);

    // R6: overflow, with merge while full allowed
    scen = "R6";
    a0 = abort_seen;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    st(1, 1); st(2, 2); st(3, 3); st(4, 4); st(4, 5);
    chk(mode_o == 2'd1, "R6", "merge while full", mode_o, 1);
    st(5, 6);
    idle(2);
    chk(abort_seen == a0 + 1, "R6", "overflow abort", abort_seen - a0, 1);

    // R9 R8: snoops during commit ignored
    scen = "R9";
    a0 = abort_seen; w0 = wr_seen;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    ld(8); st(8, 88); st(14, 140);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    snp(1, 8); snp(2, 14); snp(1, 8);
    idle(3);
    chk(abort_seen == a0 && wr_seen - w0 == 2, "R9", "commit under snoop",
        wr_seen - w0, 2);
    scen = "R8";
    chk(mode_o == 2'd0, "R8", "idle after commit", mode_o, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule